// File: doc/BRIEF.md
# Single-Wire Background Debug Host Engine

This block is the host end of a one-wire background debug link to a target microcontroller. It turns byte-level requests from a controller into timed pulses on one shared debug line, and it turns the target's pulses back into bytes. Bits are coded by the width of a low pulse. Every bit begins with a falling edge that the host drives. A separate direction output steers an external level-shifting buffer, so the line can turn around between host and target.

Before it exchanges data, the controller normally asks for a sync handshake. The host holds the line low for a long time and then releases it. The target answers with a low pulse 128 of its own clock cycles wide. The host measures that pulse in its own clock cycles and derives a timing unit from it. All later bit widths and sample points are multiples of that unit. The engine can also wait, with no time limit, for the target's acknowledge pulse. An abort input ends any request at once.

Bytes are received in one of two ways. Edge timing decides a bit from whether the target released the line before the sample point. Level sampling only looks at the line level at the sample point, which suits targets that need a slower method. The line input passes through a two-flop synchronizer before any decision is made.

Top module: `bgdHost`

## Requirements
- R1: After reset, and whenever no request is in progress, the engine drives the line high, holds the direction output low (receive) and holds reqReady high. syncWidth resets to 0, and the timing unit resets to DEFAULT_UNIT host cycles.
- R2: The direction output is high exactly while the host drives the line. While it is low, the host never drives the line low. A receive bit starts with the host driving the line low for 2 units, after which the direction output goes low.
- R3: A send request (reqOp 0) puts out the eight bits of reqData, most significant bit first. Each bit is a low pulse of 4 units for a one or 13 units for a zero, followed by the line driven high.
- R4: In both send and receive, every bit time spans 16 units from one falling edge to the next.
- R5: An edge-timed receive (reqOp 1) reads eight bits, most significant first. A bit is one if the synchronized line was seen high at any point after release, up to and including the sample point at 10 units.
- R6: A level-sampled receive (reqOp 2) takes each bit as the synchronized line level at the sample point only. A brief high that returns low before the sample point therefore reads as zero.
- R7: A sync request (reqOp 3) drives the line low for SYNC_REQ_LEN cycles, then drives it high for 4 cycles, then releases it. The width in cycles of the target's next low pulse is reported on syncWidth.
- R8: After a sync, the unit becomes floor(syncWidth/128), clamped to the range 1 to 2^UNIT_W-1. All later bits use the new unit.
- R9: An acknowledge wait (reqOp 4) ends only after the line has fallen and then risen again. It has no timeout.
- R10: An abort puts the engine in idle on the next clock edge: line high, direction low, reqReady high. The interrupted request never produces a response, and a later request works normally.
- R11: Each accepted request gives exactly one single-cycle rspValid pulse. rspData holds the received byte for reqOp 1 and 2, and 0 for all other requests.
- R12: Request codes 5 to 7 are ignored: there is no response, no activity on the line, and reqReady stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| abort | input | 1 | Ends any request in progress and returns to idle |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqOp | input | 3 | Request code: 0 send, 1 edge receive, 2 sampled receive, 3 sync, 4 acknowledge wait |
| reqData | input | 8 | Byte to send |
| reqReady | output | 1 | High while idle |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Received byte, or 0 |
| syncWidth | output | CNT_W | Last measured sync response width in cycles |
| dbgIn | input | 1 | Level seen on the debug line |
| dbgOut | output | 1 | Level the host drives onto the line |
| dbgDirTx | output | 1 | Buffer direction: 1 host drives, 0 target drives |

## Verification
The assertions assume three things about the inputs. The controller raises reqValid only while reqReady is high. The target changes the line only while the direction output is low. Target pulses last at least a few host cycles, so the synchronizer delay cannot hide a pulse. The bench's target model keeps to all three. It drives the line only after it sees the direction fall, and it sizes every pulse in whole units of the current timing. The bench issues each request only after it has sampled reqReady high, and raises abort only at moments it chose in advance.

// File: rtl/bgdPkg.sv
package bgdPkg;

  typedef enum logic [2:0] {
    OP_SEND        = 3'd0,
    OP_RECV_EDGE   = 3'd1,
    OP_RECV_SAMPLE = 3'd2,
    OP_SYNC        = 3'd3,
    OP_ACK         = 3'd4
  } opE;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TX_LOW, ST_TX_HIGH, ST_RX_DRIVE, ST_RX_WAIT,
    ST_SYNC_LOW, ST_SYNC_HIGH, ST_SYNC_FALL, ST_SYNC_MEAS,
    ST_ACK_FALL, ST_ACK_RISE, ST_DONE
  } stateE;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic shLoad;
    logic shTx;
    logic shRx;
    logic rxBit;
    logic rxTrack;
    logic unitLoad;
  } strobeT;

endpackage

// File: rtl/bgdDatapath.sv
module bgdDatapath
  import bgdPkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int UNIT_W       = 8,
  parameter int DEFAULT_UNIT = 2,
  parameter int BITS         = 8,
  parameter int ONE_UNITS    = 4,
  parameter int ZERO_UNITS   = 13,
  parameter int BIT_UNITS    = 16,
  parameter int SAMPLE_UNITS = 10,
  parameter int START_UNITS  = 2,
  parameter int SYNC_SHIFT   = 7,
  localparam int BC_W        = $clog2(BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [BITS-1:0]  loadData,
  input  logic             dbgIn,
  output logic [CNT_W-1:0] tmr,
  output logic [CNT_W-1:0] oneLen,
  output logic [CNT_W-1:0] zeroLen,
  output logic [CNT_W-1:0] bitLen,
  output logic [CNT_W-1:0] startLen,
  output logic [CNT_W-1:0] sampleLen,
  output logic             lineS,
  output logic             seenHigh,
  output logic             shMsb,
  output logic [BC_W-1:0]  bitCnt,
  output logic [BITS-1:0]  shReg,
  output logic [CNT_W-1:0] syncWidth
);

  localparam int UNIT_MAX = (1 << UNIT_W) - 1;

  logic [UNIT_W-1:0] unitReg;
  logic [UNIT_W-1:0] unitNext;
  logic [CNT_W-1:0]  unitW;
  logic [CNT_W-1:0]  measW;
  logic [CNT_W-1:0]  scaled;
  logic              syncA;

  // every timing threshold is a multiple of the calibrated unit
  assign unitW     = CNT_W'(unitReg);
  assign oneLen    = unitW * CNT_W'(ONE_UNITS);
  assign zeroLen   = unitW * CNT_W'(ZERO_UNITS);
  assign bitLen    = unitW * CNT_W'(BIT_UNITS);
  assign startLen  = unitW * CNT_W'(START_UNITS);
  assign sampleLen = unitW * CNT_W'(SAMPLE_UNITS);
  assign shMsb     = shReg[BITS-1];

  // sync width to unit, clamped to a usable range
  assign measW  = tmr + CNT_W'(1);
  assign scaled = measW >> SYNC_SHIFT;
  always_comb begin
    if (scaled == '0)                    unitNext = UNIT_W'(1);
    else if (scaled > CNT_W'(UNIT_MAX))  unitNext = UNIT_W'(UNIT_MAX);
    else                                 unitNext = scaled[UNIT_W-1:0];
  end

  // two-flop synchronizer on the shared line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      lineS <= 1'b1;
    end else begin
      syncA <= dbgIn;
      lineS <= syncA;
    end
  end

  // saturating bit timer and rise tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr      <= '0;
      seenHigh <= 1'b0;
    end else if (stb.tmrClr) begin
      tmr      <= '0;
      seenHigh <= 1'b0;
    end else begin
      if (tmr != '1) tmr <= tmr + CNT_W'(1);
      if (stb.rxTrack && lineS) seenHigh <= 1'b1;
    end
  end

  // shift register, msb first in both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (stb.shLoad) begin
      shReg  <= loadData;
      bitCnt <= '0;
    end else if (stb.shTx) begin
      shReg  <= shReg << 1;
      bitCnt <= bitCnt + BC_W'(1);
    end else if (stb.shRx) begin
      shReg  <= {shReg[BITS-2:0], stb.rxBit};
      bitCnt <= bitCnt + BC_W'(1);
    end
  end

  // calibration result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitReg   <= UNIT_W'(DEFAULT_UNIT);
      syncWidth <= '0;
    end else if (stb.unitLoad) begin
      unitReg   <= unitNext;
      syncWidth <= measW;
    end
  end

  assert_unit_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    unitReg != '0);

  assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BC_W'(BITS));

  assert_unit_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.unitLoad |=> $stable(syncWidth));

endmodule

// File: rtl/bgdCtrl.sv
module bgdCtrl
  import bgdPkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int BITS          = 8,
  parameter int SYNC_REQ_LEN  = 400,
  parameter int SYNC_HIGH_LEN = 4,
  localparam int BC_W         = $clog2(BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             abort,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  output logic             reqReady,
  output logic             rspValid,
  output logic             rspIsRx,
  output logic             dbgOut,
  output logic             dbgDirTx,
  output strobeT           stb,
  input  logic [CNT_W-1:0] tmr,
  input  logic [CNT_W-1:0] oneLen,
  input  logic [CNT_W-1:0] zeroLen,
  input  logic [CNT_W-1:0] bitLen,
  input  logic [CNT_W-1:0] startLen,
  input  logic [CNT_W-1:0] sampleLen,
  input  logic             lineS,
  input  logic             seenHigh,
  input  logic             shMsb,
  input  logic [BC_W-1:0]  bitCnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  stateE state, stNext;
  logic  modeSample, modeSampleNext;
  logic  rspIsRxNext;
  logic  [CNT_W-1:0] lowLen;

  assign lowLen = shMsb ? oneLen : zeroLen;

  always_comb begin
    stNext         = state;
    stb            = '0;
    modeSampleNext = modeSample;
    rspIsRxNext    = rspIsRx;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (reqOp == OP_SEND) begin
          stb.shLoad = 1'b1; stb.tmrClr = 1'b1;
          rspIsRxNext = 1'b0;
          stNext = ST_TX_LOW;
        end else if (reqOp == OP_RECV_EDGE || reqOp == OP_RECV_SAMPLE) begin
          stb.shLoad = 1'b1; stb.tmrClr = 1'b1;
          rspIsRxNext = 1'b1;
          modeSampleNext = (reqOp == OP_RECV_SAMPLE);
          stNext = ST_RX_DRIVE;
        end else if (reqOp == OP_SYNC) begin
          stb.tmrClr = 1'b1;
          rspIsRxNext = 1'b0;
          stNext = ST_SYNC_LOW;
        end else if (reqOp == OP_ACK) begin
          rspIsRxNext = 1'b0;
          stNext = ST_ACK_FALL;
        end
      end
      ST_TX_LOW:
        if (tmr == lowLen - ONE) stNext = ST_TX_HIGH;
      ST_TX_HIGH:
        if (tmr == bitLen - ONE) begin
          if (bitCnt == BC_W'(BITS - 1)) stNext = ST_DONE;
          else begin
            stb.shTx = 1'b1; stb.tmrClr = 1'b1;
            stNext = ST_TX_LOW;
          end
        end
      ST_RX_DRIVE:
        if (tmr == startLen - ONE) stNext = ST_RX_WAIT;
      ST_RX_WAIT: begin
        stb.rxTrack = 1'b1;
        stb.rxBit   = modeSample ? lineS : (seenHigh | lineS);
        if (tmr == sampleLen - ONE) stb.shRx = 1'b1;
        if (tmr == bitLen - ONE) begin
          if (bitCnt == BC_W'(BITS)) stNext = ST_DONE;
          else begin
            stb.tmrClr = 1'b1;
            stNext = ST_RX_DRIVE;
          end
        end
      end
      ST_SYNC_LOW:
        if (tmr == CNT_W'(SYNC_REQ_LEN - 1)) begin
          stb.tmrClr = 1'b1;
          stNext = ST_SYNC_HIGH;
        end
      ST_SYNC_HIGH:
        if (tmr == CNT_W'(SYNC_HIGH_LEN - 1)) stNext = ST_SYNC_FALL;
      ST_SYNC_FALL:
        if (!lineS) begin
          stb.tmrClr = 1'b1;
          stNext = ST_SYNC_MEAS;
        end
      ST_SYNC_MEAS:
        if (lineS) begin
          stb.unitLoad = 1'b1;
          stNext = ST_DONE;
        end
      ST_ACK_FALL:
        if (!lineS) stNext = ST_ACK_RISE;
      ST_ACK_RISE:
        if (lineS) stNext = ST_DONE;
      ST_DONE:
        stNext = ST_IDLE;
      default:
        stNext = ST_IDLE;
    endcase
    if (abort) begin
      stNext = ST_IDLE;
      stb    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      modeSample <= 1'b0;
      rspIsRx    <= 1'b0;
    end else begin
      state      <= stNext;
      modeSample <= modeSampleNext;
      rspIsRx    <= rspIsRxNext;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_DONE);
  assign dbgDirTx = (state == ST_TX_LOW) || (state == ST_TX_HIGH) ||
                    (state == ST_RX_DRIVE) || (state == ST_SYNC_LOW) ||
                    (state == ST_SYNC_HIGH);
  assign dbgOut   = !((state == ST_TX_LOW) || (state == ST_RX_DRIVE) ||
                      (state == ST_SYNC_LOW));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> reqReady && dbgOut && !dbgDirTx && !rspValid);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_tx_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dbgOut) && dbgDirTx && state == ST_TX_HIGH) |->
      ($past(tmr) == oneLen - ONE || $past(tmr) == zeroLen - ONE));

  assert_ack_no_timeout_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK_FALL && lineS && !abort) |=> state == ST_ACK_FALL);

  assert_release_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dbgDirTx) && state == ST_RX_WAIT) |-> $past(tmr) == startLen - ONE);

endmodule

// File: rtl/bgdHost.sv
module bgdHost
  import bgdPkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int UNIT_W       = 8,
  parameter int DEFAULT_UNIT = 2,
  parameter int SYNC_REQ_LEN = 400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             abort,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [7:0]       reqData,
  output logic             reqReady,
  output logic             rspValid,
  output logic [7:0]       rspData,
  output logic [CNT_W-1:0] syncWidth,
  input  logic             dbgIn,
  output logic             dbgOut,
  output logic             dbgDirTx
);

  localparam int BITS = 8;
  localparam int BC_W = $clog2(BITS + 1);

  strobeT           stb;
  logic [CNT_W-1:0] tmr, oneLen, zeroLen, bitLen, startLen, sampleLen;
  logic             lineS, seenHigh, shMsb, rspIsRx;
  logic [BC_W-1:0]  bitCnt;
  logic [BITS-1:0]  shReg;

  bgdCtrl #(
    .CNT_W(CNT_W), .BITS(BITS), .SYNC_REQ_LEN(SYNC_REQ_LEN), .SYNC_HIGH_LEN(4)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .abort(abort), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .rspValid(rspValid), .rspIsRx(rspIsRx),
    .dbgOut(dbgOut), .dbgDirTx(dbgDirTx), .stb(stb), .tmr(tmr),
    .oneLen(oneLen), .zeroLen(zeroLen), .bitLen(bitLen), .startLen(startLen),
    .sampleLen(sampleLen), .lineS(lineS), .seenHigh(seenHigh), .shMsb(shMsb),
    .bitCnt(bitCnt)
  );

  bgdDatapath #(
    .CNT_W(CNT_W), .UNIT_W(UNIT_W), .DEFAULT_UNIT(DEFAULT_UNIT), .BITS(BITS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadData(reqData), .dbgIn(dbgIn),
    .tmr(tmr), .oneLen(oneLen), .zeroLen(zeroLen), .bitLen(bitLen),
    .startLen(startLen), .sampleLen(sampleLen), .lineS(lineS),
    .seenHigh(seenHigh), .shMsb(shMsb), .bitCnt(bitCnt), .shReg(shReg),
    .syncWidth(syncWidth)
  );

  assign rspData = rspIsRx ? shReg : '0;

endmodule

// File: tb/test_bgdHost.sv
module test_bgdHost;

  localparam int CNT_W    = 16;
  localparam int DEF_U    = 2;
  localparam int SYNC_REQ = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abort = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [7:0] reqData = '0;
  logic reqReady, rspValid, dbgOut, dbgDirTx, dbgIn;
  logic [7:0] rspData;
  logic [CNT_W-1:0] syncWidth;
  logic tgtLevel = 1'b1;

  assign dbgIn = dbgDirTx ? dbgOut : tgtLevel;

  bgdHost #(.CNT_W(CNT_W), .UNIT_W(8), .DEFAULT_UNIT(DEF_U), .SYNC_REQ_LEN(SYNC_REQ)) i_bgdHost (
    .clk(clk), .rstN(rstN), .abort(abort), .reqValid(reqValid), .reqOp(reqOp),
    .reqData(reqData), .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .syncWidth(syncWidth), .dbgIn(dbgIn), .dbgOut(dbgOut), .dbgDirTx(dbgDirTx)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model: 0 silent, 1 data bits, 2 sync reply, 3 acknowledge
  int tgtMode = 0;
  logic [7:0] tgtByte = '0;
  int tgtIdx = 0;
  logic tgtGlitch = 1'b0;
  logic curBit = 1'b1;
  int relCnt = 0;
  int syncW = 256;
  int ackDelay = 200;
  int expU = DEF_U;
  logic prevDir = 1'b0;

  always @(negedge clk) begin
    if (dbgDirTx) begin
      relCnt = 0;
      tgtLevel = 1'b1;
    end else begin
      if (prevDir && tgtMode == 1) begin
        curBit = tgtByte[7 - (tgtIdx % 8)];
        tgtIdx++;
      end
      case (tgtMode)
        1: begin
          if (!curBit) tgtLevel = (relCnt >= 11 * expU);
          else if (tgtGlitch) tgtLevel = !(relCnt >= 2 && relCnt < 11 * expU);
          else tgtLevel = 1'b1;
        end
        2: tgtLevel = !(relCnt >= 10 && relCnt < 10 + syncW);
        3: tgtLevel = !(relCnt >= ackDelay && relCnt < ackDelay + 32);
        default: tgtLevel = 1'b1;
      endcase
      relCnt++;
    end
    prevDir = dbgDirTx;
  end

  // line monitor
  int cyc = 0;
  int lowCnt = 0;
  int lastOther = 0;
  int rxStart = 0;
  int txBits = 0;
  int txBad = 0;
  int lastFall = -1;
  int periodBad = 0;
  int drivenLowRx = 0;
  logic [7:0] txByte = '0;

  always @(negedge clk) begin
    cyc++;
    if (dbgDirTx && !dbgOut) begin
      if (lowCnt == 0) begin
        if (lastFall >= 0 && cyc - lastFall != 16 * expU) periodBad++;
        lastFall = cyc;
      end
      lowCnt++;
    end else if (lowCnt != 0) begin
      if (!dbgDirTx) rxStart = lowCnt;
      else if (lowCnt == 4 * expU) begin txByte = {txByte[6:0], 1'b1}; txBits++; end
      else if (lowCnt == 13 * expU) begin txByte = {txByte[6:0], 1'b0}; txBits++; end
      else if (lowCnt == SYNC_REQ) lastOther = lowCnt;
      else txBad++;
      lowCnt = 0;
    end
    if (!dbgDirTx && !dbgOut) drivenLowRx++;
  end

  task automatic issue(input logic [2:0] op, input logic [7:0] d);
    @(posedge clk);
    txByte = '0; txBits = 0; txBad = 0; periodBad = 0; lastFall = -1;
    rxStart = 0; lastOther = 0; drivenLowRx = 0; tgtIdx = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOp = op; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(input int maxCyc, output bit got, output logic [7:0] d, output int lat);
    got = 1'b0; d = '0; lat = 0;
    for (int i = 0; i < maxCyc; i++) begin
      if (rspValid) begin got = 1'b1; d = rspData; lat = i; break; end
      @(negedge clk);
    end
  endtask

  // op[31:28] glitch[27:24] data[23:16] expRsp[15:8] expTx[7:0]
  localparam logic [31:0] VEC [7] = '{
    {4'd0, 4'd0, 8'hA5, 8'h00, 8'hA5},
    {4'd0, 4'd0, 8'h00, 8'h00, 8'h00},
    {4'd0, 4'd0, 8'hFF, 8'h00, 8'hFF},
    {4'd1, 4'd0, 8'h3C, 8'h3C, 8'h00},
    {4'd2, 4'd0, 8'hC3, 8'hC3, 8'h00},
    {4'd1, 4'd1, 8'hA5, 8'hA5, 8'h00},
    {4'd2, 4'd1, 8'hA5, 8'h00, 8'h00}
  };

  task automatic sendCheck(input logic [7:0] d, input string req);
    bit got; logic [7:0] r; int lat;
    tgtMode = 0;
    issue(3'd0, d);
    waitRsp(20000, got, r, lat);
    chk(got && r == 8'h00, "R11", {got, r}, {1'b1, 8'h00});
    chk(txBits == 8 && txByte == d && txBad == 0, req, {txBits, txByte}, {8, d});
    chk(periodBad == 0, "R4", periodBad, 0);
  endtask

  task automatic syncCheck(input int w, input int newU);
    bit got; logic [7:0] r; int lat;
    tgtMode = 2; syncW = w;
    issue(3'd3, 8'h00);
    waitRsp(20000, got, r, lat);
    chk(got && r == 8'h00, "R11", {got, r}, {1'b1, 8'h00});
    chk(syncWidth == CNT_W'(w), "R7", syncWidth, w);
    chk(lastOther == SYNC_REQ, "R7", lastOther, SYNC_REQ);
    expU = newU;
    tgtMode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got; logic [7:0] r; int lat; int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady && dbgOut && !dbgDirTx && !rspValid && syncWidth == 0, "R1",
        {reqReady, dbgOut, dbgDirTx, rspValid}, 4'b1100);

    // vector walk: send and both receive modes at the reset unit (R8 default)
    for (int v = 0; v < 7; v++) begin
      logic [3:0] op; logic gl; logic [7:0] dat, expR, expT;
      op = VEC[v][31:28]; gl = VEC[v][24]; dat = VEC[v][23:16];
      expR = VEC[v][15:8]; expT = VEC[v][7:0];
      tgtMode = (op == 0) ? 0 : 1;
      tgtByte = dat; tgtGlitch = gl;
      issue(op[2:0], dat);
      waitRsp(20000, got, r, lat);
      if (op == 0) begin
        chk(got && r == expR, "R11", {got, r}, {1'b1, expR});
        chk(txBits == 8 && txByte == expT && txBad == 0, "R3", {txBits, txByte}, {8, expT});
      end else begin
        chk(got && r == expR, (op == 1) ? "R5" : "R6", {got, r}, {1'b1, expR});
        chk(rxStart == 2 * expU && drivenLowRx == 0, "R2", {rxStart, drivenLowRx}, {2 * expU, 0});
      end
      chk(periodBad == 0, "R4", periodBad, 0);
      @(negedge clk);
      chk(reqReady && dbgOut && !dbgDirTx, "R1", {reqReady, dbgOut, dbgDirTx}, 3'b110);
    end

    // R7 R8 sync calibration: 384 -> unit 3, 100 -> clamp to 1, 256 -> 2
    syncCheck(384, 3);
    sendCheck(8'h5A, "R8");
    syncCheck(100, 1);
    sendCheck(8'h81, "R8");
    syncCheck(256, 2);

    // R9 acknowledge after a command
    tgtMode = 3; ackDelay = 200;
    issue(3'd0, 8'h11);
    waitRsp(20000, got, r, lat);
    issue(3'd4, 8'h00);
    waitRsp(20000, got, r, lat);
    chk(got && r == 8'h00 && lat > 100, "R9", {got, r, lat}, {1'b1, 8'h00});

    // R9 R10 no timeout, then abort
    tgtMode = 0;
    issue(3'd4, 8'h00);
    cnt = 0;
    for (int i = 0; i < 5000; i++) begin
      if (rspValid || reqReady) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R9", cnt, 0);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(reqReady && dbgOut && !dbgDirTx, "R10", {reqReady, dbgOut, dbgDirTx}, 3'b110);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (rspValid) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R10", cnt, 0);

    // R10 abort mid-send, then a clean send
    issue(3'd0, 8'h00);
    repeat (40) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(reqReady && dbgOut && !dbgDirTx, "R10", {reqReady, dbgOut, dbgDirTx}, 3'b110);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      if (rspValid || dbgDirTx) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R10", cnt, 0);
    sendCheck(8'hC3, "R10");

    // R12 unused code
    issue(3'd6, 8'h55);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      if (rspValid || !reqReady || dbgDirTx || !dbgOut) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0 && lastFall == -1, "R12", cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule